// File: doc/BRIEF.md
# 16-bit Arithmetic, Logic and Shift Unit

This block performs one of sixteen data operations on a pair of 16-bit operands and reports four status flags with the result. A 4-bit function select and a carry input form a five-bit control word. The top two select bits choose one of four function groups: arithmetic, bitwise logic, right shift/rotate, and left shift/rotate. The lower two bits choose the operation inside that group. All four groups evaluate the operands at the same time, and a group multiplexer passes one of them to the output.

The carry input changes the arithmetic results by one. It also supplies the bit that enters a rotate-through-carry. In the house two-process layout the result and flags are captured in one register stage. The outputs therefore show the operation selected at the previous rising clock edge. A surrounding datapath drives operands from its register file and stores the flags wherever it needs them.

Top module: `alsu_core`

## Requirements
- R1: While `rst_n` is low, `f_out` and all four flags (`v_out`, `s_out`, `z_out`, `c_out`) are 0.
- R2: After each rising clock edge with reset released, the outputs show the operation on the `a_in`, `b_in`, `sel_in` and `cin_in` values sampled at that edge. The latency is exactly one cycle.
- R3: The arithmetic group is `sel_in[3:2]=00`. It computes A + Y + cin, where Y is 0 for `sel_in[1:0]=00`, B for 01, the bitwise inverse of B for 10, and all ones for 11. This gives A or A+1, A+B or A+B+1, A-B-1 or A-B, and A-1 or A.
- R4: In the arithmetic group, C is the carry out of bit 15 of that sum. V is 1 exactly when the true signed result lies outside -32768..32767.
- R5: The logic group is `sel_in[3:2]=01`. Selects 00, 01, 10 and 11 give A AND B, A OR B, A XOR B and NOT A, in that order. C and V are both 0.
- R6: The right group is `sel_in[3:2]=10`. Each operation moves A one place toward bit 0. The bit entering bit 15 is 0 for select 00 (logical), A[0] for 01 (rotate), cin for 10 (rotate through carry), and A[15] for 11 (arithmetic). C is A[0] and V is 0.
- R7: The left group is `sel_in[3:2]=11`. Each operation moves A one place toward bit 15. The bit entering bit 0 is 0 for select 00 and 11 (logical and arithmetic), A[15] for 01 (rotate), and cin for 10 (rotate through carry). C is A[15]. V is 0, except for the arithmetic left shift, where V is A[15] XOR A[14].
- R8: `cin_in` has no effect on any result or flag in the logic group, or in the right or left groups other than the two rotate-through-carry selects (1010 and 1110).
- R9: Z is 1 exactly when the 16-bit result is zero. S equals bit 15 of the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; outputs update on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| a_in | input | 16 | First operand; the only operand of shifts, rotates and NOT |
| b_in | input | 16 | Second operand |
| sel_in | input | 4 | Function select; bits 3:2 pick the group, bits 1:0 the operation |
| cin_in | input | 1 | Carry input |
| f_out | output | 16 | Result |
| v_out | output | 1 | Signed overflow flag |
| s_out | output | 1 | Sign flag |
| z_out | output | 1 | Zero flag |
| c_out | output | 1 | Carry / shifted-out bit flag |

## Verification
The block holds state only in its output register. An internal fault therefore shows at the ports on the first edge after the offending inputs, and it shows as a wrong result bit or flag for that one operation. Faults in a group mux or a sub-unit select show only for particular select codes. For that reason every one of the sixteen codes is run with both carry-input values and with operands that reach the corner cases: overflow in both directions, borrow, a zero result, and the sign bit entering or leaving. A carry input that leaks into the wrong group shows as a result that differs between two otherwise identical runs.

// File: rtl/alsu_pkg.sv
package alsu_pkg;

    typedef enum logic [1:0] {
        GRP_ARITH = 2'b00,
        GRP_LOGIC = 2'b01,
        GRP_RIGHT = 2'b10,
        GRP_LEFT  = 2'b11
    } alsu_grp_e;

    typedef enum logic [1:0] {
        SH_PLAIN  = 2'b00,
        SH_ROT    = 2'b01,
        SH_ROTC   = 2'b10,
        SH_ARITH  = 2'b11
    } alsu_shift_e;

    typedef struct packed {
        logic carry;
        logic ovf;
    } alsu_side_t;

endpackage

// File: rtl/alsu_arith.sv
module alsu_arith
    import alsu_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic [1:0]       op_i,
    input  logic             cin_i,
    output logic [WIDTH-1:0] res_o,
    output alsu_side_t       side_o
);
    localparam int SUM_W = WIDTH + 1;

    logic [WIDTH-1:0] y_d;
    logic [SUM_W-1:0] sum_d;

    always_comb begin
        unique case (op_i)
            2'b00:   y_d = '0;
            2'b01:   y_d = b_i;
            2'b10:   y_d = ~b_i;
            default: y_d = '1;
        endcase
        sum_d = {1'b0, a_i} + {1'b0, y_d} + {{(SUM_W-1){1'b0}}, cin_i};
        res_o = sum_d[WIDTH-1:0];
        side_o.carry = sum_d[WIDTH];
        side_o.ovf   = (a_i[WIDTH-1] == y_d[WIDTH-1]) &&
                       (sum_d[WIDTH-1] != a_i[WIDTH-1]);
    end

endmodule

// File: rtl/alsu_logic.sv
module alsu_logic
    import alsu_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic [1:0]       op_i,
    output logic [WIDTH-1:0] res_o,
    output alsu_side_t       side_o
);

    always_comb begin
        unique case (op_i)
            2'b00:   res_o = a_i & b_i;
            2'b01:   res_o = a_i | b_i;
            2'b10:   res_o = a_i ^ b_i;
            default: res_o = ~a_i;
        endcase
        side_o = '0;
    end

endmodule

// File: rtl/alsu_shift.sv
module alsu_shift
    import alsu_pkg::*;
#(
    parameter int WIDTH = 16,
    parameter bit LEFT  = 1'b0
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [1:0]       op_i,
    input  logic             cin_i,
    output logic [WIDTH-1:0] res_o,
    output alsu_side_t       side_o
);
    localparam int MSB = WIDTH - 1;

    alsu_shift_e mode_d;
    logic        fill_d;

    assign mode_d = alsu_shift_e'(op_i);

    generate
        if (LEFT) begin : gen_left
            always_comb begin
                unique case (mode_d)
                    SH_ROT:  fill_d = a_i[MSB];
                    SH_ROTC: fill_d = cin_i;
                    default: fill_d = 1'b0;
                endcase
                res_o        = {a_i[MSB-1:0], fill_d};
                side_o.carry = a_i[MSB];
                side_o.ovf   = (mode_d == SH_ARITH) ? (a_i[MSB] ^ a_i[MSB-1]) : 1'b0;
            end
        end else begin : gen_right
            always_comb begin
                unique case (mode_d)
                    SH_ROT:   fill_d = a_i[0];
                    SH_ROTC:  fill_d = cin_i;
                    SH_ARITH: fill_d = a_i[MSB];
                    default:  fill_d = 1'b0;
                endcase
                res_o        = {fill_d, a_i[MSB:1]};
                side_o.carry = a_i[0];
                side_o.ovf   = 1'b0;
            end
        end
    endgenerate

endmodule

// File: rtl/alsu_core.sv
module alsu_core
    import alsu_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] a_in,
    input  logic [WIDTH-1:0] b_in,
    input  logic [3:0]       sel_in,
    input  logic             cin_in,
    output logic [WIDTH-1:0] f_out,
    output logic             v_out,
    output logic             s_out,
    output logic             z_out,
    output logic             c_out
);
    localparam int MSB    = WIDTH - 1;
    localparam int N_GRP  = 4;

    typedef struct packed {
        logic [WIDTH-1:0] f;
        logic             v;
        logic             s;
        logic             z;
        logic             c;
    } out_t;

    logic [WIDTH-1:0] grp_res [N_GRP];
    alsu_side_t       grp_side [N_GRP];
    alsu_grp_e        grp_sel;
    out_t             out_d, out_q;
    logic             past_valid_d, past_valid_q;

    assign grp_sel = alsu_grp_e'(sel_in[3:2]);

    alsu_arith #(.WIDTH(WIDTH)) u_arith (
        .a_i    (a_in),
        .b_i    (b_in),
        .op_i   (sel_in[1:0]),
        .cin_i  (cin_in),
        .res_o  (grp_res[GRP_ARITH]),
        .side_o (grp_side[GRP_ARITH])
    );

    alsu_logic #(.WIDTH(WIDTH)) u_logic (
        .a_i    (a_in),
        .b_i    (b_in),
        .op_i   (sel_in[1:0]),
        .res_o  (grp_res[GRP_LOGIC]),
        .side_o (grp_side[GRP_LOGIC])
    );

    alsu_shift #(.WIDTH(WIDTH), .LEFT(1'b0)) u_right (
        .a_i    (a_in),
        .op_i   (sel_in[1:0]),
        .cin_i  (cin_in),
        .res_o  (grp_res[GRP_RIGHT]),
        .side_o (grp_side[GRP_RIGHT])
    );

    alsu_shift #(.WIDTH(WIDTH), .LEFT(1'b1)) u_left (
        .a_i    (a_in),
        .op_i   (sel_in[1:0]),
        .cin_i  (cin_in),
        .res_o  (grp_res[GRP_LEFT]),
        .side_o (grp_side[GRP_LEFT])
    );

    always_comb begin
        out_d.f = grp_res[grp_sel];
        out_d.c = grp_side[grp_sel].carry;
        out_d.v = grp_side[grp_sel].ovf;
        out_d.z = ~|out_d.f;
        out_d.s = out_d.f[MSB];
        past_valid_d = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q        <= '0;
            past_valid_q <= 1'b0;
        end else begin
            out_q        <= out_d;
            past_valid_q <= past_valid_d;
        end
    end

    assign f_out = out_q.f;
    assign v_out = out_q.v;
    assign s_out = out_q.s;
    assign z_out = out_q.z;
    assign c_out = out_q.c;

    // R3: pass-through select returns the operand seen one edge earlier
    a_r3_pass_through: assert property (@(posedge clk) disable iff (!rst_n || !past_valid_q)
        ($past(sel_in) == 4'b0000 && !$past(cin_in)) |-> (f_out == $past(a_in)));

    // R5: logic group never reports carry or overflow
    a_r5_logic_flags_clear: assert property (@(posedge clk) disable iff (!rst_n || !past_valid_q)
        ($past(sel_in[3:2]) == 2'b01) |-> (!c_out && !v_out));

    // R6: right group carry is the old bit 0
    a_r6_right_carry: assert property (@(posedge clk) disable iff (!rst_n || !past_valid_q)
        ($past(sel_in[3:2]) == 2'b10) |-> (c_out == $past(a_in[0]) && !v_out));

    // R7: left group carry is the old top bit
    a_r7_left_carry: assert property (@(posedge clk) disable iff (!rst_n || !past_valid_q)
        ($past(sel_in[3:2]) == 2'b11) |-> (c_out == $past(a_in[MSB])));

    // R7: arithmetic left shift flags a sign change
    a_r7_asl_overflow: assert property (@(posedge clk) disable iff (!rst_n || !past_valid_q)
        ($past(sel_in) == 4'b1111) |-> (v_out == ($past(a_in[MSB]) ^ $past(a_in[MSB-1]))));

    // R8: rotate through carry inserts the carry input
    a_r8_rorc_fill: assert property (@(posedge clk) disable iff (!rst_n || !past_valid_q)
        ($past(sel_in) == 4'b1010) |-> (f_out[MSB] == $past(cin_in)));

    a_r8_rolc_fill: assert property (@(posedge clk) disable iff (!rst_n || !past_valid_q)
        ($past(sel_in) == 4'b1110) |-> (f_out[0] == $past(cin_in)));

    // R1: reset holds everything cleared
    a_r1_reset_clear: assert property (@(posedge clk)
        $past(!rst_n) |-> (f_out == '0 && !v_out && !s_out && !z_out && !c_out));

endmodule

// File: tb/alsu_core_tb_top.sv
module alsu_core_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] a_in = '0;
    logic [15:0] b_in = '0;
    logic [3:0]  sel_in = '0;
    logic        cin_in = 1'b0;
    logic [15:0] f_out;
    logic        v_out, s_out, z_out, c_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    alsu_core #(.WIDTH(16)) dut_i (
        .clk(clk), .rst_n(rst_n), .a_in(a_in), .b_in(b_in), .sel_in(sel_in),
        .cin_in(cin_in), .f_out(f_out), .v_out(v_out), .s_out(s_out),
        .z_out(z_out), .c_out(c_out)
    );

    // expected {f, v, s, z, c} from the requirement text
    function automatic logic [19:0] model(input logic [15:0] a, input logic [15:0] b,
                                          input logic [3:0] sel, input logic ci);
        logic [15:0] f;
        logic v, c;
        int ua, sa;
        f = '0; v = 1'b0; c = 1'b0;
        case (sel[3:2])
            2'b00: begin
                case (sel[1:0])
                    2'b00: begin ua = int'(a) + int'(ci);                  sa = int'($signed(a)) + int'(ci); end
                    2'b01: begin ua = int'(a) + int'(b) + int'(ci);        sa = int'($signed(a)) + int'($signed(b)) + int'(ci); end
                    2'b10: begin ua = int'(a) + (65535 - int'(b)) + int'(ci); sa = int'($signed(a)) - int'($signed(b)) - 1 + int'(ci); end
                    default: begin ua = int'(a) + 65535 + int'(ci);        sa = int'($signed(a)) - 1 + int'(ci); end
                endcase
                f = ua[15:0];
                c = (ua > 65535);
                v = (sa > 32767) || (sa < -32768);
            end
            2'b01: begin
                case (sel[1:0])
                    2'b00: f = a & b;
                    2'b01: f = a | b;
                    2'b10: f = a ^ b;
                    default: f = ~a;
                endcase
            end
            2'b10: begin
                f = a >> 1;
                if (sel[1:0] == 2'b01) f[15] = a[0];
                if (sel[1:0] == 2'b10) f[15] = ci;
                if (sel[1:0] == 2'b11) f[15] = a[15];
                c = a[0];
            end
            default: begin
                f = a << 1;
                if (sel[1:0] == 2'b01) f[0] = a[15];
                if (sel[1:0] == 2'b10) f[0] = ci;
                if (sel[1:0] == 2'b11) v = a[15] ^ a[14];
                c = a[15];
            end
        endcase
        return {f, v, f[15], (f == 16'h0), c};
    endfunction

    task automatic compare(input string req, input logic [19:0] act, input logic [19:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got f=%h vszc=%b, expected f=%h vszc=%b",
                     req, act[19:4], act[3:0], exp[19:4], exp[3:0]);
        end
    endtask

    // drive at a falling edge, sample at the next falling edge (one register between)
    task automatic run_op(input string req, input logic [15:0] a, input logic [15:0] b,
                          input logic [3:0] sel, input logic ci);
        @(negedge clk);
        a_in = a; b_in = b; sel_in = sel; cin_in = ci;
        @(negedge clk);
        compare(req, {f_out, v_out, s_out, z_out, c_out}, model(a, b, sel, ci));
    endtask

    task automatic test_reset();
        a_in = 16'hFFFF; b_in = 16'h1234; sel_in = 4'b0001; cin_in = 1'b1;
        repeat (3) @(negedge clk);
        compare("R1", {f_out, v_out, s_out, z_out, c_out}, 20'h0);
        rst_n = 1'b1;
    endtask

    task automatic test_latency();
        @(negedge clk);
        a_in = 16'h0003; b_in = 16'h0004; sel_in = 4'b0001; cin_in = 1'b0;
        @(posedge clk); #1;
        a_in = 16'h1000; b_in = 16'h0001;
        @(negedge clk);
        compare("R2", {f_out, v_out, s_out, z_out, c_out}, {16'h0007, 4'b0000});
        @(negedge clk);
        compare("R2", {f_out, v_out, s_out, z_out, c_out}, {16'h1001, 4'b0000});
    endtask

    task automatic test_arith();
        logic [15:0] av [6] = '{16'h0000, 16'h0001, 16'h7FFF, 16'h8000, 16'hFFFF, 16'h1234};
        logic [15:0] bv [6] = '{16'h0000, 16'h0001, 16'h0001, 16'hFFFF, 16'h8000, 16'h1234};
        for (int i = 0; i < 6; i++)
            for (int s = 0; s < 4; s++)
                for (int c = 0; c < 2; c++)
                    run_op("R3/R4", av[i], bv[i], 4'(s), 1'(c));
        run_op("R4", 16'h7FFF, 16'h0001, 4'b0001, 1'b0);
        compare("R4", {f_out, v_out, s_out, z_out, c_out}, {16'h8000, 4'b1100});
        run_op("R9", 16'h0005, 16'h0005, 4'b0010, 1'b1);
        compare("R9", {f_out, v_out, s_out, z_out, c_out}, {16'h0000, 4'b0011});
    endtask

    task automatic test_logic();
        for (int s = 0; s < 4; s++)
            for (int c = 0; c < 2; c++) begin
                run_op("R5/R8", 16'hF0A5, 16'h3C0F, 4'(4 + s), 1'(c));
                run_op("R5/R9", 16'hFFFF, 16'hFFFF, 4'(4 + s), 1'(c));
            end
    endtask

    task automatic test_right();
        logic [15:0] av [4] = '{16'h8001, 16'h4000, 16'h0001, 16'hFFFE};
        for (int i = 0; i < 4; i++)
            for (int s = 0; s < 4; s++)
                for (int c = 0; c < 2; c++)
                    run_op("R6/R8", av[i], 16'h5555, 4'(8 + s), 1'(c));
        run_op("R6", 16'h8001, 16'h0, 4'b1011, 1'b0);
        compare("R6", {f_out, v_out, s_out, z_out, c_out}, {16'hC000, 4'b0101});
    endtask

    task automatic test_left();
        logic [15:0] av [4] = '{16'h8001, 16'h4000, 16'h0001, 16'hC000};
        for (int i = 0; i < 4; i++)
            for (int s = 0; s < 4; s++)
                for (int c = 0; c < 2; c++)
                    run_op("R7/R8", av[i], 16'hAAAA, 4'(12 + s), 1'(c));
        run_op("R7", 16'h4000, 16'h0, 4'b1111, 1'b0);
        compare("R7", {f_out, v_out, s_out, z_out, c_out}, {16'h8000, 4'b1100});
        run_op("R8", 16'h0000, 16'h0, 4'b1110, 1'b1);
        compare("R8", {f_out, v_out, s_out, z_out, c_out}, {16'h0001, 4'b0000});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R2: watchdog expired, got no completion, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        test_reset();
        test_latency();
        test_arith();
        test_logic();
        test_right();
        test_left();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule